// File: doc/BRIEF.md
# Fractional-Resolution PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer. The timer counts from zero up to a programmable period value and then wraps. A prescaler sits in front of it and divides by 1, 4 or 16. The duty value is 10 bits wide, two bits finer than the timer. Software writes it as an upper byte and a separate 2-bit lower field. The compare appends two sub-count bits below the timer count. With no prescaling those bits come from a free-running 2-bit counter that advances every clock. With prescaling they are the two lowest bits of the prescaler.

The written duty value is never compared directly. It is copied into a shadow register only when a period starts. A write in the middle of a period therefore never shortens or stretches the pulse that is already running. At each period start the output goes high, unless the new duty is zero. It goes low again when the extended count first equals the shadow duty. If the duty reaches past the period, that equality never occurs and the output stays high for the whole period.

The intended setup order is: program the period, program the duty, select the prescale ratio, then raise `en`.

Top module: `pwm_fracgen`

## Requirements
- R1: A synchronous reset drives `pwm_o` to 0 and clears the stored period and duty values to zero, so enabling after reset without writing a duty keeps `pwm_o` low.
- R2: While `en` is 0, `pwm_o` is 0 and every counter is held at zero. The first rising edge that samples `en` high starts a period, and `pwm_o` shows offset 0 of that period from that edge on.
- R3: `psc_sel` selects the prescale ratio: 0 gives 1, 1 gives 4, 2 or 3 gives 16. One timer step lasts 4 × ratio clocks, and one period lasts (period + 1) × 4 × ratio clocks.
- R4: Duty bits 9:2 come from `duty_hi_wdata` and bits 1:0 from `duty_lo_wdata`. With duty D, the high time is D clocks for ratio 1. For ratio 4 or 16 it is 4 × ratio × (D >> 2) + 4 × (D & 3) clocks.
- R5: A duty value of 0 keeps `pwm_o` low for the entire period.
- R6: When D >> 2 is greater than the period value, `pwm_o` stays high for the entire period.
- R7: A duty write takes effect only at the next period start. The period in progress keeps the duty that was latched when it began.
- R8: `pwm_o` rises only at a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the timer and the output; low holds everything at zero |
| psc_sel | input | 2 | Prescale select: 0 for /1, 1 for /4, 2 or 3 for /16 |
| period_wdata | input | 8 | Period value (the last timer count of a period) |
| period_we | input | 1 | Write strobe for the period value |
| duty_hi_wdata | input | 8 | Upper eight duty bits (9:2) |
| duty_hi_we | input | 1 | Write strobe for the upper duty bits |
| duty_lo_wdata | input | 2 | Lower two duty bits (1:0) |
| duty_lo_we | input | 1 | Write strobe for the lower duty bits |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench sweeps every duty value, from zero to past the period, for small period values at every prescale ratio. It compares each clock of two whole periods against high and period lengths computed arithmetically.

- An off-by-one in the compare timing would show as a pulse one clock too long or too short.
- Taking the sub-count bits from the wrong source at a prescale of 4 or 16 would scale the fractional part of the pulse wrongly.
- A design that let the compare wrap would clear the output when the duty exceeds the period, where it must stay high.
- A duty written early in a period would, without the shadow copy, stretch the running pulse to the new value.
- A restart after disabling that kept stale counter state would shift every edge.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
  // Prescaler counter width: enough for the largest ratio (16).
  localparam int PSC_W = 4;

  localparam logic [1:0] SEL_DIV1  = 2'd0;
  localparam logic [1:0] SEL_DIV4  = 2'd1;

  // Last prescaler count for a given ratio select.
  function automatic logic [PSC_W-1:0] pre_last(input logic [1:0] sel);
    logic [PSC_W-1:0] r;
    case (sel)
      SEL_DIV1: r = '0;
      SEL_DIV4: r = PSC_W'(3);
      default:  r = '1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwmf_timebase.sv
// Sub-count, prescaler and period timer. Outputs are the next-state
// values so that the output stage can register a decision that lines
// up with the counters.
module pwmf_timebase #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        psc_sel,
  input  logic [CNT_W-1:0]  period,
  output logic              start,
  output logic              wrap,
  output logic [CNT_W-1:0]  tmr_n,
  output logic [FRAC_W-1:0] sub_n
);
  import pwmf_pkg::*;

  logic              run_q;
  logic [FRAC_W-1:0] q_q, q_n;
  logic [PSC_W-1:0]  p_q, p_n, p_last;
  logic [CNT_W-1:0]  tmr_q;
  logic [FRAC_W-1:0] pre_bits;
  logic              advance, q_full, tick;

  assign advance = en & run_q;
  assign q_full  = &q_q;
  assign p_last  = pre_last(psc_sel);
  assign tick    = advance & q_full & (p_q == p_last);
  assign wrap    = tick & (tmr_q == period);
  assign start   = en & ~run_q;

  always_comb begin
    q_n   = '0;
    p_n   = '0;
    tmr_n = '0;
    if (advance) begin
      q_n   = q_q + 1'b1;
      p_n   = p_q;
      tmr_n = tmr_q;
      if (q_full) begin
        p_n = (p_q == p_last) ? '0 : p_q + 1'b1;
      end
      if (tick) begin
        tmr_n = (tmr_q == period) ? '0 : tmr_q + 1'b1;
      end
    end
  end

  generate
    if (FRAC_W <= PSC_W) begin : g_sub_direct
      assign pre_bits = p_n[FRAC_W-1:0];
    end else begin : g_sub_pad
      assign pre_bits = {{(FRAC_W-PSC_W){1'b0}}, p_n};
    end
  endgenerate

  assign sub_n = (psc_sel == SEL_DIV1) ? q_n : pre_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      q_q   <= '0;
      p_q   <= '0;
      tmr_q <= '0;
    end else begin
      run_q <= en;
      q_q   <= q_n;
      p_q   <= p_n;
      tmr_q <= tmr_n;
    end
  end
endmodule

// File: rtl/pwmf_duty_buf.sv
// Software-visible period and duty registers plus the duty shadow.
module pwmf_duty_buf #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  period_wdata,
  input  logic              period_we,
  input  logic [CNT_W-1:0]  duty_hi_wdata,
  input  logic              duty_hi_we,
  input  logic [FRAC_W-1:0] duty_lo_wdata,
  input  logic              duty_lo_we,
  output logic [CNT_W-1:0]  period_r,
  output logic [DUTY_W-1:0] shadow_n
);
  logic [DUTY_W-1:0] duty_r;
  logic [DUTY_W-1:0] shadow_q;

  assign shadow_n = load ? duty_r : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_r <= '0;
      duty_r   <= '0;
      shadow_q <= '0;
    end else begin
      if (period_we)  period_r <= period_wdata;
      if (duty_hi_we) duty_r[DUTY_W-1:FRAC_W] <= duty_hi_wdata;
      if (duty_lo_we) duty_r[FRAC_W-1:0] <= duty_lo_wdata;
      shadow_q <= shadow_n;
    end
  end
endmodule

// File: rtl/pwmf_out.sv
// Output register: set at period start, cleared on extended-count match.
module pwmf_out #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [CNT_W-1:0]  tmr_n,
  input  logic [FRAC_W-1:0] sub_n,
  input  logic [DUTY_W-1:0] shadow_n,
  output logic              pwm_q
);
  logic match;
  logic pwm_d;

  assign match = ({tmr_n, sub_n} == shadow_n);

  always_comb begin
    if (!en)        pwm_d = 1'b0;
    else if (load)  pwm_d = (shadow_n != '0);
    else if (match) pwm_d = 1'b0;
    else            pwm_d = pwm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_d;
  end
endmodule

// File: rtl/pwm_fracgen.sv
module pwm_fracgen #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        psc_sel,
  input  logic [CNT_W-1:0]  period_wdata,
  input  logic              period_we,
  input  logic [CNT_W-1:0]  duty_hi_wdata,
  input  logic              duty_hi_we,
  input  logic [FRAC_W-1:0] duty_lo_wdata,
  input  logic              duty_lo_we,
  output logic              pwm_o
);
  logic              start, wrap, load;
  logic [CNT_W-1:0]  tmr_n, period_r;
  logic [FRAC_W-1:0] sub_n;
  logic [DUTY_W-1:0] shadow_n;

  assign load = start | wrap;

  pwmf_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .psc_sel (psc_sel),
    .period  (period_r),
    .start   (start),
    .wrap    (wrap),
    .tmr_n   (tmr_n),
    .sub_n   (sub_n)
  );

  pwmf_duty_buf #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_buf (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .period_wdata  (period_wdata),
    .period_we     (period_we),
    .duty_hi_wdata (duty_hi_wdata),
    .duty_hi_we    (duty_hi_we),
    .duty_lo_wdata (duty_lo_wdata),
    .duty_lo_we    (duty_lo_we),
    .period_r      (period_r),
    .shadow_n      (shadow_n)
  );

  pwmf_out #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .tmr_n    (tmr_n),
    .sub_n    (sub_n),
    .shadow_n (shadow_n),
    .pwm_q    (pwm_o)
  );
endmodule

// File: rtl/pwmf_checker.sv
module pwmf_checker #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              pwm_o,
  input logic              load,
  input logic              match,
  input logic [CNT_W-1:0]  tmr_q,
  input logic [FRAC_W-1:0] q_q,
  input logic [3:0]        p_q,
  input logic [CNT_W-1:0]  period_r,
  input logic [DUTY_W-1:0] duty_r,
  input logic [DUTY_W-1:0] shadow_q
);
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o); // R2
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tmr_q == '0 && q_q == '0 && p_q == '0)); // R2
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> $past(load)); // R8
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow_q)); // R7
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (load && duty_r == '0) |=> !pwm_o); // R5
  AST_LONG_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (load && duty_r[DUTY_W-1:FRAC_W] > period_r) |=> pwm_o); // R6
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_o) |-> ($past(!en) || $past(match))); // R4
endmodule

bind pwm_fracgen pwmf_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .pwm_o    (pwm_o),
  .load     (load),
  .match    (u_out.match),
  .tmr_q    (u_tb.tmr_q),
  .q_q      (u_tb.q_q),
  .p_q      (u_tb.p_q),
  .period_r (period_r),
  .duty_r   (u_buf.duty_r),
  .shadow_q (u_buf.shadow_q)
);

// File: tb/pwm_fracgen_tb.sv
module pwm_fracgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] psc_sel = 2'd0;
  logic [7:0] period_wdata = '0;
  logic       period_we = 1'b0;
  logic [7:0] duty_hi_wdata = '0;
  logic       duty_hi_we = 1'b0;
  logic [1:0] duty_lo_wdata = '0;
  logic       duty_lo_we = 1'b0;
  logic       pwm_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fracgen u_dut (
    .clk(clk), .rst(rst), .en(en), .psc_sel(psc_sel),
    .period_wdata(period_wdata), .period_we(period_we),
    .duty_hi_wdata(duty_hi_wdata), .duty_hi_we(duty_hi_we),
    .duty_lo_wdata(duty_lo_wdata), .duty_lo_we(duty_lo_we),
    .pwm_o(pwm_o)
  );

  function automatic int ratio(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  function automatic int per_len(int sel, int per);
    return (per + 1) * 4 * ratio(sel);
  endfunction

  function automatic int hi_len(int sel, int per, int duty);
    if ((duty >> 2) > per) return per_len(sel, per);
    if (sel == 0) return duty;
    return 4 * ratio(sel) * (duty >> 2) + 4 * (duty & 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(int sel, int per, int duty);
    @(negedge clk);
    en = 1'b0;
    psc_sel = 2'(sel);
    period_wdata = 8'(per);
    period_we = 1'b1;
    duty_hi_wdata = 8'(duty >> 2);
    duty_hi_we = 1'b1;
    duty_lo_wdata = 2'(duty & 3);
    duty_lo_we = 1'b1;
    @(negedge clk);
    period_we = 1'b0;
    duty_hi_we = 1'b0;
    duty_lo_we = 1'b0;
  endtask

  // Enables at the current negedge and compares nper whole periods.
  task automatic run_periods(int sel, int per, int duty, int nper, string req);
    int plen = per_len(sel, per);
    int hlen = hi_len(sel, per, duty);
    int miss = 0;
    int first_i = -1;
    int first_v = 0;
    en = 1'b1;
    for (int i = 0; i < nper * plen; i++) begin
      @(negedge clk);
      if (pwm_o !== ((i % plen) < hlen)) begin
        if (first_i < 0) begin
          first_i = i;
          first_v = int'(pwm_o);
        end
        miss++;
      end
    end
    en = 1'b0;
    if (miss != 0)
      $display("  sel=%0d per=%0d duty=%0d first bad offset=%0d pwm=%0d",
               sel, per, duty, first_i, first_v);
    chk(miss == 0, req, miss, 0);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    int a_bad;
    // R1: reset clears output and stored duty
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 output low in reset", int'(pwm_o), 0);
    en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    period_wdata = 8'd3;
    period_we = 1'b1;
    @(negedge clk);
    period_we = 1'b0;
    run_periods(0, 3, 0, 2, "R1 duty cleared by reset");

    // R3 R4 R5 R6: sweep at ratio 1
    for (int per = 0; per < 4; per++)
      for (int d = 0; d <= 4 * (per + 1) + 4; d++) begin
        write_cfg(0, per, d);
        run_periods(0, per, d, 2, (d == 0) ? "R5 zero duty /1" :
                    ((d >> 2) > per) ? "R6 duty beyond period /1" : "R4 high time /1");
      end
    // R3 R4: ratio 4
    for (int per = 0; per < 3; per += 2)
      for (int d = 0; d <= 4 * (per + 1) + 4; d++) begin
        write_cfg(1, per, d);
        run_periods(1, per, d, 2, ((d >> 2) > per) ? "R6 duty beyond period /4" :
                    "R3 R4 high time /4");
      end
    // R3 R4: ratio 16 via both select codes
    for (int sel = 2; sel < 4; sel++)
      for (int d = 0; d <= 12; d++) begin
        write_cfg(sel, 1, d);
        run_periods(sel, 1, d, 2, "R3 R4 high time /16");
      end

    // R7: duty rewritten early in a period applies only to the next one
    write_cfg(0, 3, 5);
    en = 1'b1;
    a_bad = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pwm_o !== ((i < 16) ? ((i % 16) < 5) : ((i % 16) < 11))) a_bad++;
      if (i == 2) begin
        duty_hi_wdata = 8'd2;
        duty_lo_wdata = 2'd3;
        duty_hi_we = 1'b1;
        duty_lo_we = 1'b1;
      end else begin
        duty_hi_we = 1'b0;
        duty_lo_we = 1'b0;
      end
    end
    en = 1'b0;
    chk(a_bad == 0, "R7 shadow update at period start", a_bad, 0);

    // R2: disable mid-period forces low, re-enable restarts at offset 0
    write_cfg(0, 3, 10);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b1, "R2 running before disable", int'(pwm_o), 1);
    en = 1'b0;
    a_bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_o !== 1'b0) a_bad++;
    end
    chk(a_bad == 0, "R2 low while disabled", a_bad, 0);
    run_periods(0, 3, 10, 2, "R2 restart from offset 0");

    // R8: a write while disabled must not raise the output
    write_cfg(0, 3, 12);
    repeat (4) @(negedge clk);
    chk(pwm_o == 1'b0, "R8 no rise outside period start", int'(pwm_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule